// File: doc/BRIEF.md
# Shadow-ROM Memory Decoder with Bank Window

This block decodes the 16-bit address of an 8-bit CPU into chip selects for a 32 KB ROM, a 512 KB SRAM and a 2 KB peripheral area. It also produces the 19-bit physical SRAM address. After reset the upper 32 KB is a shadow region. Reads there are served by the ROM, while writes to the same addresses land in the RAM underneath. Boot code can therefore copy itself into RAM at its own addresses. A single write to a control location then retires the ROM. After that every read in the upper half comes from RAM, and 62 KB of RAM is visible to the CPU.

The addresses $D000-$DFFF form a 4 KB window. It can be pointed at any of the 128 pages of the SRAM through a 7-bit page register at $F280. The CPU can read that register back. The peripheral area $F000-$F7FF is cut into 32 slots of 64 bytes, and each slot has its own active-low strobe. Two of the slots hold the block's own control locations and drive no strobe. Every select is gated by the E bus-clock phase.

The overlay is a two-state machine. In state ST_SHADOW, upper-half reads go to ROM. In state ST_RAM_ONLY, they go to RAM. The only transition, named overlay_retire, goes from ST_SHADOW to ST_RAM_ONLY on an E-qualified write to $F2C0. ST_RAM_ONLY holds until reset, and reset always returns the machine to ST_SHADOW.

Top module: `shadow_bank_decoder`

## Requirements
- R1: After reset the overlay is active (state ST_SHADOW) and the page register holds 0.
- R2: An access to $F000-$F7FF asserts neither rom_cs_n nor ram_cs_n.
- R3: A write anywhere outside the peripheral area selects RAM and never ROM, whatever the overlay state.
- R4: While the overlay is active, a read of $8000-$FFFF outside the peripheral area asserts rom_cs_n and not ram_cs_n. ROM and RAM are never selected together.
- R5: A write to $F2C0 retires the overlay, after which upper-half reads select RAM. Further writes to $F2C0 leave it retired, and only reset restores it.
- R6: Outside the window, a RAM access drives ram_addr = {3'b000, cpu_addr}.
- R7: Inside $D000-$DFFF, a RAM access drives ram_addr = {page, cpu_addr[11:0]}.
- R8: A write to $F280 loads cpu_wdata[6:0] into the page register. A read of $F280 returns {1'b0, page} with cpu_rdata_oe high. The register is unchanged by any other access.
- R9: While cpu_e is low, no chip select, no strobe and no read-data enable asserts, and writes to the control locations have no effect.
- R10: In the peripheral area, io_cs_n[k] goes low for slot k = cpu_addr[10:6]. At most one strobe is low at a time. Slots 10 ($F280) and 11 ($F2C0) never drive their strobe.
- R11: While ROM is selected, rom_addr equals cpu_addr[14:0].
- R12: Data written through the window on page p, then overwritten at the same CPU address on page q, reads back with its original value on page p, and the value from page q reads back on page q.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock for the control registers |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address bus |
| cpu_rw | input | 1 | 1 = read, 0 = write |
| cpu_e | input | 1 | E bus-clock phase; access valid while high |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | Read data for the page register |
| cpu_rdata_oe | output | 1 | High while the block drives read data |
| rom_cs_n | output | 1 | ROM chip select, active low |
| rom_addr | output | 15 | ROM address lines |
| ram_cs_n | output | 1 | SRAM chip select, active low |
| ram_addr | output | 19 | Physical SRAM address |
| io_cs_n | output | 32 | Peripheral slot strobes, active low |

## Verification
The bench builds the decoder with its default parameters: a 19-bit physical address, 4 KB pages and 64-byte slots. These values make page 127 reachable, so writing $FF to the page register exercises both the top page and the dropped upper data bit. Bench-side models of the RAM contents and the register state predict every output independently of the design. The window round trip, the E-low writes that must be ignored, and a second reset that restores the ROM overlay are all covered.

// File: rtl/sbd_pkg.sv
package sbd_pkg;
    localparam int ADDR_W       = 16;
    localparam int DATA_W       = 8;
    localparam int PHYS_W       = 19;
    localparam int PAGE_SHIFT   = 12;
    localparam int PAGE_W       = PHYS_W - PAGE_SHIFT;
    localparam int IO_SPAN_LOG2 = 11;
    localparam int SLOT_LOG2    = 6;
    localparam int SLOT_W       = IO_SPAN_LOG2 - SLOT_LOG2;
    localparam int SLOT_CNT     = 1 << SLOT_W;

    localparam logic [ADDR_W-1:0] IO_BASE   = 16'hF000;
    localparam logic [ADDR_W-1:0] WIN_BASE  = 16'hD000;
    localparam logic [ADDR_W-1:0] PAGE_CTL  = 16'hF280;
    localparam logic [ADDR_W-1:0] OVL_CTL   = 16'hF2C0;

    typedef enum logic {
        ST_SHADOW   = 1'b0,
        ST_RAM_ONLY = 1'b1
    } ovl_state_t;
endpackage

// File: rtl/shadow_ctrl.sv
module shadow_ctrl
    import sbd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic retire_req,
    output logic overlay_on
);
    ovl_state_t state_q;
    ovl_state_t state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_SHADOW;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SHADOW:   if (retire_req) state_d = ST_RAM_ONLY;
            ST_RAM_ONLY: state_d = ST_RAM_ONLY;
            default:     state_d = ST_SHADOW;
        endcase
    end

    always_comb begin
        unique case (state_q)
            ST_SHADOW:   overlay_on = 1'b1;
            ST_RAM_ONLY: overlay_on = 1'b0;
            default:     overlay_on = 1'b1;
        endcase
    end
endmodule

// File: rtl/page_reg.sv
module page_reg #(
    parameter int PAGE_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [PAGE_W-1:0] din,
    output logic [PAGE_W-1:0] page
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    page <= '0;
        else if (load) page <= din;
    end
endmodule

// File: rtl/periph_decode.sv
module periph_decode #(
    parameter int                ADDR_W       = 16,
    parameter int                IO_SPAN_LOG2 = 11,
    parameter int                SLOT_LOG2    = 6,
    parameter logic [ADDR_W-1:0] IO_BASE      = 16'hF000,
    parameter int                PRIV_A       = 10,
    parameter int                PRIV_B       = 11,
    localparam int               SLOT_W       = IO_SPAN_LOG2 - SLOT_LOG2,
    localparam int               SLOT_CNT     = 1 << SLOT_W
) (
    input  logic [ADDR_W-1:0]   addr,
    input  logic                e,
    output logic                io_hit,
    output logic [SLOT_CNT-1:0] io_cs_n
);
    logic [SLOT_W-1:0] slot;
    logic              unused_low;

    assign io_hit     = (addr[ADDR_W-1:IO_SPAN_LOG2] == IO_BASE[ADDR_W-1:IO_SPAN_LOG2]);
    assign slot       = addr[IO_SPAN_LOG2-1:SLOT_LOG2];
    assign unused_low = ^addr[SLOT_LOG2-1:0];

    for (genvar g = 0; g < SLOT_CNT; g++) begin : g_slot
        if (g == PRIV_A || g == PRIV_B) begin : g_priv
            assign io_cs_n[g] = 1'b1;
        end else begin : g_ext
            assign io_cs_n[g] = ~(e & io_hit & (slot == SLOT_W'(g)));
        end
    end
endmodule

// File: rtl/shadow_bank_decoder.sv
module shadow_bank_decoder
    import sbd_pkg::*;
#(
    parameter int                ADDR_BITS = ADDR_W,
    parameter int                DATA_BITS = DATA_W,
    parameter int                PHYS_BITS = PHYS_W,
    parameter int                PG_SHIFT  = PAGE_SHIFT,
    parameter logic [ADDR_W-1:0] WIN_ADDR  = WIN_BASE,
    parameter logic [ADDR_W-1:0] PAGE_ADDR = PAGE_CTL,
    parameter logic [ADDR_W-1:0] OVL_ADDR  = OVL_CTL,
    localparam int               PG_W      = PHYS_BITS - PG_SHIFT,
    localparam int               N_SLOT    = SLOT_CNT
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_BITS-1:0] cpu_addr,
    input  logic                 cpu_rw,
    input  logic                 cpu_e,
    input  logic [DATA_BITS-1:0] cpu_wdata,
    output logic [DATA_BITS-1:0] cpu_rdata,
    output logic                 cpu_rdata_oe,
    output logic                 rom_cs_n,
    output logic [ADDR_BITS-2:0] rom_addr,
    output logic                 ram_cs_n,
    output logic [PHYS_BITS-1:0] ram_addr,
    output logic [N_SLOT-1:0]    io_cs_n
);
    localparam int PRIV_PAGE = int'(PAGE_ADDR[IO_SPAN_LOG2-1:SLOT_LOG2]);
    localparam int PRIV_OVL  = int'(OVL_ADDR[IO_SPAN_LOG2-1:SLOT_LOG2]);

    logic            rd_cycle;
    logic            wr_cycle;
    logic            upper;
    logic            in_win;
    logic            io_hit;
    logic            overlay_on;
    logic            page_load;
    logic            retire_req;
    logic [PG_W-1:0] page_q;
    logic            unused_wd;

    assign rd_cycle   = cpu_e &  cpu_rw;
    assign wr_cycle   = cpu_e & ~cpu_rw;
    assign upper      = cpu_addr[ADDR_BITS-1];
    assign in_win     = (cpu_addr[ADDR_BITS-1:PG_SHIFT] == WIN_ADDR[ADDR_BITS-1:PG_SHIFT]);
    assign page_load  = wr_cycle & (cpu_addr == PAGE_ADDR);
    assign retire_req = wr_cycle & (cpu_addr == OVL_ADDR);
    assign unused_wd  = ^cpu_wdata[DATA_BITS-1:PG_W];

    shadow_ctrl u_shadow (
        .clk        (clk),
        .rst_n      (rst_n),
        .retire_req (retire_req),
        .overlay_on (overlay_on)
    );

    page_reg #(.PAGE_W(PG_W)) u_page (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (page_load),
        .din   (cpu_wdata[PG_W-1:0]),
        .page  (page_q)
    );

    periph_decode #(
        .ADDR_W       (ADDR_BITS),
        .IO_SPAN_LOG2 (IO_SPAN_LOG2),
        .SLOT_LOG2    (SLOT_LOG2),
        .IO_BASE      (IO_BASE),
        .PRIV_A       (PRIV_PAGE),
        .PRIV_B       (PRIV_OVL)
    ) u_io (
        .addr    (cpu_addr),
        .e       (cpu_e),
        .io_hit  (io_hit),
        .io_cs_n (io_cs_n)
    );

    always_comb begin
        rom_cs_n = ~(rd_cycle & upper & ~io_hit & overlay_on);
        ram_cs_n = ~(cpu_e & ~io_hit & ~(upper & cpu_rw & overlay_on));
        rom_addr = cpu_addr[ADDR_BITS-2:0];
        if (in_win) ram_addr = {page_q, cpu_addr[PG_SHIFT-1:0]};
        else        ram_addr = {{(PHYS_BITS-ADDR_BITS){1'b0}}, cpu_addr};
        cpu_rdata_oe = rd_cycle & (cpu_addr == PAGE_ADDR);
        if (cpu_rdata_oe) cpu_rdata = {{(DATA_BITS-PG_W){1'b0}}, page_q};
        else              cpu_rdata = '0;
    end
endmodule

// File: rtl/shadow_bank_decoder_chk.sv
module shadow_bank_decoder_chk
    import sbd_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic [ADDR_W-1:0]   cpu_addr,
    input logic                cpu_rw,
    input logic                cpu_e,
    input logic                rom_cs_n,
    input logic                ram_cs_n,
    input logic [PHYS_W-1:0]   ram_addr,
    input logic [SLOT_CNT-1:0] io_cs_n,
    input logic                overlay_on,
    input logic [PAGE_W-1:0]   page_q
);
    logic in_io;
    logic in_win;
    assign in_io  = cpu_addr[ADDR_W-1:IO_SPAN_LOG2] == IO_BASE[ADDR_W-1:IO_SPAN_LOG2];
    assign in_win = cpu_addr[ADDR_W-1:PAGE_SHIFT] == WIN_BASE[ADDR_W-1:PAGE_SHIFT];

    p_io_no_mem_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_e && in_io) |-> (rom_cs_n && ram_cs_n));

    p_write_not_rom_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_rw |-> rom_cs_n);

    p_one_memory_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rom_cs_n && !ram_cs_n));

    p_ovl_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !overlay_on |=> !overlay_on);

    p_ovl_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(overlay_on) |-> $past(cpu_e && !cpu_rw && cpu_addr == OVL_CTL));

    p_win_map_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!ram_cs_n && in_win) |-> (ram_addr[PHYS_W-1:PAGE_SHIFT] == page_q));

    p_page_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_e && !cpu_rw && cpu_addr == PAGE_CTL) |=> $stable(page_q));

    p_idle_e_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_e |-> (rom_cs_n && ram_cs_n && (&io_cs_n)));

    p_strobe_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~io_cs_n));
endmodule

bind shadow_bank_decoder shadow_bank_decoder_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_addr   (cpu_addr),
    .cpu_rw     (cpu_rw),
    .cpu_e      (cpu_e),
    .rom_cs_n   (rom_cs_n),
    .ram_cs_n   (ram_cs_n),
    .ram_addr   (ram_addr),
    .io_cs_n    (io_cs_n),
    .overlay_on (overlay_on),
    .page_q     (page_q)
);

// File: tb/shadow_bank_decoder_test.sv
module shadow_bank_decoder_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic        cpu_rw = 1'b1;
    logic        cpu_e = 1'b0;
    logic [7:0]  cpu_wdata = '0;
    logic [7:0]  cpu_rdata;
    logic        cpu_rdata_oe;
    logic        rom_cs_n;
    logic [14:0] rom_addr;
    logic        ram_cs_n;
    logic [18:0] ram_addr;
    logic [31:0] io_cs_n;

    always #10 clk = ~clk;

    shadow_bank_decoder uut (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rw(cpu_rw),
        .cpu_e(cpu_e), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .cpu_rdata_oe(cpu_rdata_oe), .rom_cs_n(rom_cs_n), .rom_addr(rom_addr),
        .ram_cs_n(ram_cs_n), .ram_addr(ram_addr), .io_cs_n(io_cs_n)
    );

    typedef struct {
        string       req;
        logic        rom_n;
        logic        ram_n;
        logic [18:0] raddr;
        logic [14:0] oaddr;
        logic [31:0] io_n;
        logic        oe;
        logic [7:0]  dout;
    } exp_t;

    exp_t        sb_q[$];
    event        do_sample;
    int          checks = 0;
    int          fails = 0;
    bit          done = 1'b0;
    logic [7:0]  mem [int];
    logic [7:0]  rd_val;
    bit          m_ovl;
    logic [6:0]  m_page;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: pops the expected item and compares it with the outputs.
    always @(do_sample) begin
        exp_t x;
        if (sb_q.size() == 0) begin
            check(1'b0, "SB-empty", 0, 1);
        end else begin
            x = sb_q.pop_front();
            check(rom_cs_n === x.rom_n, {x.req, " rom_cs_n"}, 32'(rom_cs_n), 32'(x.rom_n));
            check(ram_cs_n === x.ram_n, {x.req, " ram_cs_n"}, 32'(ram_cs_n), 32'(x.ram_n));
            check(io_cs_n === x.io_n, {x.req, " io_cs_n"}, io_cs_n, x.io_n);
            check(cpu_rdata_oe === x.oe, {x.req, " rdata_oe"}, 32'(cpu_rdata_oe), 32'(x.oe));
            if (!x.ram_n) check(ram_addr === x.raddr, {x.req, " ram_addr"}, 32'(ram_addr), 32'(x.raddr));
            if (!x.rom_n) check(rom_addr === x.oaddr, {x.req, " rom_addr"}, 32'(rom_addr), 32'(x.oaddr));
            if (x.oe) check(cpu_rdata === x.dout, {x.req, " rdata"}, 32'(cpu_rdata), 32'(x.dout));
        end
    end

    // Driver: predicts the outputs from the requirements, then runs one bus cycle.
    task automatic bus(input logic [15:0] a, input bit rw, input logic [7:0] d, input bit e, input string req);
        exp_t x;
        bit io  = (a >= 16'hF000) && (a <= 16'hF7FF);
        bit win = (a >= 16'hD000) && (a <= 16'hDFFF);
        int slot = (int'(a) - 16'hF000) >>> 6;
        x.req   = req;
        x.rom_n = !(e && rw && a[15] && !io && m_ovl);
        x.ram_n = !(e && !io && !(a[15] && rw && m_ovl));
        x.raddr = win ? {m_page, a[11:0]} : {3'b000, a};
        x.oaddr = a[14:0];
        x.io_n  = '1;
        if (e && io && slot != 10 && slot != 11) x.io_n[slot] = 1'b0;
        x.oe    = e && rw && (a == 16'hF280);
        x.dout  = {1'b0, m_page};
        sb_q.push_back(x);
        @(negedge clk);
        cpu_addr = a; cpu_rw = rw; cpu_wdata = d; cpu_e = e;
        #5;
        -> do_sample;
        #1;
        if (!ram_cs_n) begin
            if (!rw) mem[int'(ram_addr)] = d;
            else     rd_val = mem.exists(int'(ram_addr)) ? mem[int'(ram_addr)] : 8'hxx;
        end
        if (e && !rw && a == 16'hF280) m_page = d[6:0];
        if (e && !rw && a == 16'hF2C0) m_ovl = 1'b0;
        @(negedge clk);
        cpu_e = 1'b0; cpu_rw = 1'b1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; cpu_e = 1'b0;
        m_ovl = 1'b1; m_page = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        do_reset();
        bus(16'hFFFE, 1, 8'h00, 0, "R9 idle at reset");
        bus(16'hFFFE, 1, 8'h00, 1, "R1 R4 R11 boot fetch from ROM");
        bus(16'hF280, 1, 8'h00, 1, "R1 R8 page reads 0 after reset");
        bus(16'h9000, 0, 8'h11, 1, "R3 shadow write to RAM");
        bus(16'h9000, 1, 8'h00, 1, "R4 shadow read from ROM");
        bus(16'hF100, 1, 8'h00, 1, "R2 R10 slot 4");
        bus(16'hF7C0, 0, 8'h00, 1, "R2 R10 slot 31");
        bus(16'hF2C4, 1, 8'h00, 1, "R10 slot 11 silent");
        bus(16'h1234, 1, 8'h00, 1, "R6 low RAM read");
        bus(16'h7FFF, 0, 8'h22, 1, "R6 low RAM write");
        bus(16'hF2C0, 0, 8'h00, 0, "R9 E-low retire ignored");
        bus(16'h9000, 1, 8'h00, 1, "R9 overlay still on");
        bus(16'hF280, 0, 8'h33, 0, "R9 E-low page write ignored");
        bus(16'hF280, 1, 8'h00, 1, "R9 R8 page still 0");
        bus(16'hF2C0, 0, 8'h00, 1, "R5 retire overlay");
        bus(16'h9000, 1, 8'h00, 1, "R5 read now from RAM");
        check(rd_val === 8'h11, "R5 shadowed data", 32'(rd_val), 32'h11);
        bus(16'hF2C0, 0, 8'h00, 1, "R5 second retire");
        bus(16'hFFFE, 1, 8'h00, 1, "R5 still RAM");
        // Window round trip across pages 5 and 127.
        bus(16'hF280, 0, 8'h05, 1, "R8 set page p");
        bus(16'hD800, 0, 8'h3C, 1, "R7 R12 write A on p");
        bus(16'hF280, 0, 8'hFF, 1, "R8 set page q");
        bus(16'hF280, 1, 8'h00, 1, "R8 readback drops bit 7");
        bus(16'hD800, 0, 8'hA5, 1, "R7 R12 write B on q");
        bus(16'hF280, 0, 8'h05, 1, "R8 back to p");
        bus(16'hD800, 1, 8'h00, 1, "R7 R12 read on p");
        check(rd_val === 8'h3C, "R12 data A on page p", 32'(rd_val), 32'h3C);
        bus(16'hF280, 0, 8'h7F, 1, "R8 back to q");
        bus(16'hD800, 1, 8'h00, 1, "R7 R12 read on q");
        check(rd_val === 8'hA5, "R12 data B on page q", 32'(rd_val), 32'hA5);
        bus(16'hE000, 0, 8'h44, 1, "R6 R3 above window");
        do_reset();
        bus(16'hF280, 1, 8'h00, 1, "R1 page cleared by reset");
        bus(16'h9000, 1, 8'h00, 1, "R1 R5 reset restores ROM");
        repeat (2) @(negedge clk);
        if (sb_q.size() != 0) check(1'b0, "SB-leftover", sb_q.size(), 0);
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            done = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule